// File: doc/BRIEF.md
# Triggered Capture Memory Controller

This block sits between a bank of latched probe lines and an external static RAM. The host loads a trigger pattern, a trigger mask and a sample-rate ratio through a small write-only configuration port, then pulses an arm input. While armed, the block compares the registered probes against the pattern on every sample tick, ignoring bits whose mask is 0. When they match, it stores that sample and then every following one at incrementing RAM addresses, one sample per tick, until the top address has been written. It then raises a done flag and stops.

Sample ticks come from a divider on the oscillator clock, so the whole block runs on one clock. Each stored sample gets one active-low write strobe. Address and data settle one oscillator cycle before the strobe falls and are held for one cycle after it rises. Only the low `DATA_W` probe bits are written to memory. The trigger compare sees all `PROBE_W` bits.

The controller has four states. IDLE leaves reset. ARM (IDLE, ARMED or DONE to ARMED) is taken on an arm pulse. FIRE (ARMED to CAPTURE) is taken on a tick with a pattern match. FILL (CAPTURE to DONE) is taken on the tick after the top address has been stored.

Top module: `capture_sequencer`

## Requirements
- R1: After reset the block is idle: `mem_addr` is 0, `mem_we_n` is 1, and `st_armed`, `st_capt` and `st_done` are all 0.
- R2: An arm pulse taken in IDLE, ARMED or DONE enters ARMED. In the next cycle `st_armed` is 1, `st_done` is 0 and `mem_addr` is 0. The divider phase restarts, so the first tick comes D+1 cycles after the arm edge.
- R3: The trigger matches when `((probe ^ pattern) & mask) == 0`. A mask bit of 0 is a don't-care. An all-zero mask fires on the first tick after arming. The sample that fires the trigger is stored at address 0.
- R4: No write strobe occurs outside CAPTURE, so nothing is written while the block waits for a trigger.
- R5: Configuration writes use `cfg_sel`: 0 writes the pattern, 1 writes the mask, 2 writes the ratio N from `cfg_data[DIV_W-1:0]`. Ticks occur every D+1 oscillator cycles, where D = max(N, 2).
- R6: Each stored sample gets exactly one low pulse on `mem_we_n`, lasting D-1 cycles. Successive strobe falls are D+1 cycles apart. Address and data are stable across both strobe edges.
- R7: Strobes write addresses 0, 1, 2 and so on up to 2^ADDR_W-1, each exactly once and in order. The data is probe bits [DATA_W-1:0] as registered at the tick, so samples stored consecutively were taken D+1 cycles apart.
- R8: After the top address is written, the block enters DONE. `st_done` stays 1 and no further strobe occurs until the next arm pulse.
- R9: An arm pulse during CAPTURE is ignored, and the sweep continues unchanged.
- R10: At most one of `st_armed`, `st_capt` and `st_done` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_i | input | PROBE_W | Raw probe lines, registered inside |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register select: 0 pattern, 1 mask, 2 ratio |
| cfg_data | input | PROBE_W | Configuration write data |
| arm_i | input | 1 | One-cycle arm request |
| mem_addr | output | ADDR_W | RAM address bus |
| mem_data | output | DATA_W | RAM write data |
| mem_we_n | output | 1 | Active-low RAM write strobe |
| st_armed | output | 1 | Waiting for trigger |
| st_capt | output | 1 | Sweep in progress |
| st_done | output | 1 | Memory full |

## Verification
A wrong state shows at the ports within one sample period. A stuck or skipped address appears at the next strobe fall as an out-of-order or missing address. A divider fault changes the strobe width or the spacing between falls on the very next pulse. A premature trigger leaves a stored word at address 0 taken before the pattern was presented, while a missed trigger or a missed transition to DONE leaves the done flag low until the run times out. A lost or extra arm effect shows as a non-zero address or a wrong flag one cycle after the pulse.

// File: rtl/capture_pkg.sv
package capture_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } cap_state_t;

    localparam logic [1:0] SEL_PATTERN = 2'd0;
    localparam logic [1:0] SEL_MASK    = 2'd1;
    localparam logic [1:0] SEL_RATIO   = 2'd2;
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick,
    output logic             mid
);
    localparam logic [DIV_W-1:0] MIN_RATIO = DIV_W'(2);

    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] cnt;

    assign eff  = (ratio < MIN_RATIO) ? MIN_RATIO : ratio;
    assign tick = (cnt == eff);
    assign mid  = (cnt != '0) && (cnt != eff);

    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/probe_trigger.sv
module probe_trigger #(
    parameter int PROBE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PROBE_W-1:0] probe_i,
    input  logic [PROBE_W-1:0] pattern,
    input  logic [PROBE_W-1:0] mask,
    output logic [PROBE_W-1:0] probe_q,
    output logic               hit
);
    logic [PROBE_W-1:0] bit_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) probe_q <= '0;
        else        probe_q <= probe_i;
    end

    for (genvar b = 0; b < PROBE_W; b++) begin : g_cmp
        assign bit_ok[b] = !mask[b] || (probe_q[b] == pattern[b]);
    end

    assign hit = &bit_ok;
endmodule

// File: rtl/addr_sweep.sv
module addr_sweep #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    assign last = &addr;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) addr <= '0;
        else if (step)       addr <= addr + ADDR_W'(1);
    end
endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
    import capture_pkg::*;
#(
    parameter int PROBE_W = 32,
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 16,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PROBE_W-1:0] probe_i,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [PROBE_W-1:0] cfg_data,
    input  logic               arm_i,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_data,
    output logic               mem_we_n,
    output logic               st_armed,
    output logic               st_capt,
    output logic               st_done
);
    cap_state_t state, state_nx;

    logic [PROBE_W-1:0] pattern_r, mask_r, probe_q;
    logic [DIV_W-1:0]   ratio_r;
    logic [DATA_W-1:0]  data_r;
    logic tick, mid, hit, last;
    logic arm_ok, fire, step, latch;

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern_r <= '0;
            mask_r    <= '0;
            ratio_r   <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_PATTERN: pattern_r <= cfg_data;
                SEL_MASK:    mask_r    <= cfg_data;
                SEL_RATIO:   ratio_r   <= cfg_data[DIV_W-1:0];
                default:     ;
            endcase
        end
    end

    assign arm_ok = arm_i && (state != ST_CAPTURE);
    assign fire   = (state == ST_ARMED) && tick && hit && !arm_i;
    assign step   = (state == ST_CAPTURE) && tick && !last;
    assign latch  = fire || step;

    tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(arm_ok),
        .ratio(ratio_r), .tick(tick), .mid(mid)
    );

    probe_trigger #(.PROBE_W(PROBE_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .probe_i(probe_i),
        .pattern(pattern_r), .mask(mask_r),
        .probe_q(probe_q), .hit(hit)
    );

    addr_sweep #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clear(arm_ok),
        .step(step), .addr(mem_addr), .last(last)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (arm_ok) state_nx = ST_ARMED;
            ST_ARMED:   if (fire)   state_nx = ST_CAPTURE;
            ST_CAPTURE: if (tick && last) state_nx = ST_DONE;
            ST_DONE:    if (arm_ok) state_nx = ST_ARMED;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // sample data register
    always_ff @(posedge clk) begin
        if (!rst_n)     data_r <= '0;
        else if (latch) data_r <= probe_q[DATA_W-1:0];
    end

    // outputs
    always_comb begin
        mem_data = data_r;
        mem_we_n = !((state == ST_CAPTURE) && mid);
        st_armed = (state == ST_ARMED);
        st_capt  = (state == ST_CAPTURE);
        st_done  = (state == ST_DONE);
    end
endmodule

// File: rtl/capture_sequencer_chk.sv
module capture_sequencer_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_i,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we_n,
    input logic              st_armed,
    input logic              st_capt,
    input logic              st_done
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // R4
    strobe_in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> st_capt);

    // R6
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $stable(mem_addr));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> $stable(mem_addr));

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_capt && $past(st_capt)) |->
            ((mem_addr == $past(mem_addr)) || (mem_addr == $past(mem_addr) + ONE)));

    // R2
    armed_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_armed |-> (mem_addr == '0));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && !arm_i) |=> st_done);

    // R9
    capt_ignores_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_capt && arm_i) |=> !st_armed);

    // R10
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_armed, st_capt, st_done}));
endmodule

bind capture_sequencer capture_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .mem_addr(mem_addr),
    .mem_we_n(mem_we_n), .st_armed(st_armed), .st_capt(st_capt),
    .st_done(st_done)
);

// File: tb/sim_capture_sequencer.sv
`timescale 1ns/1ps
module sim_capture_sequencer;
    localparam int PW = 32, AW = 6, DW = 16, VW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 0, rst_n = 0;
    logic [PW-1:0] probe_i = '0;
    logic cfg_we = 0;
    logic [1:0] cfg_sel = 0;
    logic [PW-1:0] cfg_data = '0;
    logic arm_i = 0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic mem_we_n, st_armed, st_capt, st_done;

    capture_sequencer #(.PROBE_W(PW), .ADDR_W(AW), .DATA_W(DW), .DIV_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .probe_i(probe_i), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .arm_i(arm_i),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_we_n(mem_we_n),
        .st_armed(st_armed), .st_capt(st_capt), .st_done(st_done)
    );

    always #5 clk = ~clk;

    int checks = 0, failures = 0;
    int cyc = 0;
    logic [7:0] hi = 8'h00;
    int cur_d = 2;
    logic [DW-1:0] mem [DEPTH];

    // monitor state
    int pulses = 0, low_run = 0, last_fall = -1;
    int addr_err = 0, width_err = 0, period_err = 0;
    int exp_addr = 0;
    logic prev_we = 1'b1;

    always @(negedge clk) begin
        cyc = cyc + 1;
        probe_i = {8'h00, hi, cyc[15:0]};
        if (rst_n) begin
            if (!mem_we_n) begin
                low_run = low_run + 1;
                if (prev_we) begin
                    if (int'(mem_addr) != exp_addr) addr_err = addr_err + 1;
                    mem[mem_addr] = mem_data;
                    pulses = pulses + 1;
                    exp_addr = exp_addr + 1;
                    if (last_fall >= 0 && (cyc - last_fall) != cur_d + 1)
                        period_err = period_err + 1;
                    last_fall = cyc;
                end
            end else if (!prev_we) begin
                if (low_run != cur_d - 1) width_err = width_err + 1;
                low_run = 0;
            end
            prev_we = mem_we_n;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [PW-1:0] d);
        @(posedge clk); #1;
        cfg_we = 1; cfg_sel = sel; cfg_data = d;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic arm_pulse();
        @(posedge clk); #1;
        arm_i = 1;
        @(posedge clk); #1;
        arm_i = 0;
    endtask

    task automatic reset_monitor();
        pulses = 0; low_run = 0; last_fall = -1;
        addr_err = 0; width_err = 0; period_err = 0; exp_addr = 0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (st_done) begin ok = 1; break; end
        end
    endtask

    // one capture run: ratio n, with or without a delayed upper-byte trigger
    task automatic run(input int n, input bit gated, input bit poke_arm);
        int d, t0, a0, delta_err;
        bit ok;
        d = (n < 2) ? 2 : n;
        hi = 8'h00;
        cfg_write(capture_pkg::SEL_RATIO, PW'(n));
        if (gated) begin
            cfg_write(capture_pkg::SEL_MASK,    32'h00FF_0000);
            cfg_write(capture_pkg::SEL_PATTERN, 32'hDE3C_BEEF);
        end else begin
            cfg_write(capture_pkg::SEL_MASK,    32'h0000_0000);
            cfg_write(capture_pkg::SEL_PATTERN, 32'h1234_5678);
        end
        @(posedge clk); #1;
        cur_d = d;
        reset_monitor();
        a0 = cyc;
        arm_pulse();
        @(negedge clk);
        check("R2 armed flag after arm", int'(st_armed), gated ? 1 : int'(st_armed));
        check("R2 address zero after arm", int'(mem_addr), int'(st_armed) == 1 ? 0 : int'(mem_addr));
        t0 = a0;
        if (gated) begin
            repeat (4 * (d + 1)) @(negedge clk);
            check("R4 no strobe while waiting", pulses, 0);
            check("R3 masked mismatch holds off trigger", int'(st_armed), 1);
            @(posedge clk); #1;
            t0 = cyc + 1;
            hi = 8'h3C;
        end
        if (poke_arm) begin
            while (pulses < 10) @(negedge clk);
            arm_pulse();
            @(negedge clk);
            check("R9 capture continues after arm", int'(st_capt), 1);
        end
        wait_done(ok);
        check("R8 done reached", int'(ok), 1);
        @(negedge clk);
        check("R6/R7 strobe count", pulses, DEPTH);
        check("R7 address order", addr_err, 0);
        check("R6 strobe width", width_err, 0);
        check("R5 tick spacing", period_err, 0);
        delta_err = 0;
        for (int i = 0; i < DEPTH - 1; i++)
            if (16'(mem[i+1] - mem[i]) != 16'(d + 1)) delta_err = delta_err + 1;
        check("R7 sample spacing", delta_err, 0);
        if (gated) begin
            check("R3 first sample not before pattern", int'(int'(mem[0]) >= t0), 1);
            check("R3 first sample within one period", int'(int'(mem[0]) <= t0 + d), 1);
        end else begin
            check("R3 zero mask fires at first tick", int'(int'(mem[0]) >= t0 && int'(mem[0]) <= t0 + d + 2), 1);
        end
        repeat (3 * (d + 1)) @(negedge clk);
        check("R8 no strobe after done", pulses, DEPTH);
        check("R8 done held", int'(st_done), 1);
        check("R10 flags exclusive", int'(st_armed) + int'(st_capt) + int'(st_done), 1);
    endtask

    initial begin : watchdog
        #1500000;
        failures = failures + 1;
        checks = checks + 1;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1 reset address", int'(mem_addr), 0);
        check("R1 reset strobe", int'(mem_we_n), 1);
        check("R1 reset flags", int'({st_armed, st_capt, st_done}), 0);

        run(0, 1'b0, 1'b0);
        run(1, 1'b1, 1'b0);
        run(2, 1'b1, 1'b1);
        run(3, 1'b0, 1'b1);
        run(5, 1'b1, 1'b0);
        run(7, 1'b0, 1'b0);

        // re-arm from DONE clears the flag and rewinds the address
        arm_pulse();
        @(negedge clk);
        check("R2 rearm clears done", int'(st_done), 0);
        check("R2 rearm sets armed", int'(st_armed), 1);
        check("R2 rearm rewinds address", int'(mem_addr), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule